// File: doc/BRIEF.md
# I2C Slave Address Recognizer

This block sits behind the bit-level receiver of an I2C target and decides whether the byte or bytes that follow a START condition select this device. The receiver hands it whole bytes with a one-cycle valid strobe and flags each START and repeated START. The recognizer compares the address phase against a programmed address and reports the outcome as a one-cycle hit pulse, a sticky general-call flag and the transfer direction. The data phase, acknowledge driving and bit timing belong to other logic. That logic should only act on bytes once a hit has been seen.

Two addressing widths are selectable at run time. In the narrow mode one byte carries a 7-bit address and the direction bit. In the wide mode a marker byte carries the two top address bits, and a second byte carries the low eight. A read in wide mode is a marker byte with the read bit set, sent after a repeated START that directly follows a completed wide write selection. The all-zero general call can be enabled separately and is recognized in either mode.

Top module: `slv_addr_recog`

## Requirements
- R1: After reset `hit_o`, `gcall_o` and `dir_rd_o` are 0, and every byte strobe seen before the first START or repeated START has no effect on any output.
- R2: In narrow mode (`wide_sel_i`=0), a first byte whose bits 7..1 equal `own_lo_i[6:0]` makes `hit_o` high for exactly the cycle after its strobe edge, and `dir_rd_o` takes the byte's bit 0 (1 = read).
- R3: With `gcall_en_i`=1 a first byte of 0x00 gives a hit with `gcall_o`=1 and `dir_rd_o`=0 in either mode; with `gcall_en_i`=0 the byte 0x00 gives no hit; `gcall_o` stays high until the next START or repeated START clears it.
- R4: An own 7-bit address of zero never matches; in narrow mode `own_lo_i[7]` and `own_hi_i` have no effect on the outcome.
- R5: In wide mode a first byte of the form 11110 b9 b8 0 (b9..b8 equal to `own_hi_i[1:0]`) gives no pulse; a second byte equal to `own_lo_i[7:0]` then gives a hit with `dir_rd_o`=0, and any other second byte gives none.
- R6: `own_hi_i[2]` has no effect in either mode.
- R7: In wide mode a first byte 11110 b9 b8 1 gives a hit with `dir_rd_o`=1 only when the previous first byte led to a completed wide write hit and only repeated STARTs came in between; a plain START, or any other evaluated first byte, cancels that permission.
- R8: A START or repeated START puts the block back to waiting for a first address byte; when it arrives in the same cycle as a byte strobe, the byte is discarded.
- R9: Once an address phase has ended, hit or miss, later bytes are ignored until the next START or repeated START.
- R10: `hit_o` is never high for two cycles in a row and is never high unless a byte strobe was present in the previous cycle.
- R11: `dir_rd_o` keeps its value between hits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_start_i | input | 1 | One-cycle pulse: START seen |
| bus_rstart_i | input | 1 | One-cycle pulse: repeated START seen |
| byte_vld_i | input | 1 | One-cycle strobe: `byte_i` holds a complete byte |
| byte_i | input | 8 | Received byte, bit 7 first on the wire |
| own_lo_i | input | 8 | Own address bits 7..0 (bits 6..0 in narrow mode) |
| own_hi_i | input | 3 | Own address bits 10..8, used in wide mode only |
| wide_sel_i | input | 1 | 0 = 7-bit addressing, 1 = 10-bit addressing |
| gcall_en_i | input | 1 | 1 = answer the general call |
| hit_o | output | 1 | One-cycle pulse: this device is addressed |
| gcall_o | output | 1 | Last hit was a general call |
| dir_rd_o | output | 1 | Direction of the last hit, 1 = read |

## Verification
The bench builds the block with its default parameters: eight-bit bytes, a three-bit upper address field of which two bits travel in the marker byte, and the 11110 marker. With these values the wide mode and its read-after-write rule are reachable within short random transactions, and the unused upper address bit can be toggled to show it is ignored. The random mix is biased toward bytes that almost match, such as the marker with the wrong top bits or the wrong direction, and toward repeated STARTs between wide transactions.

// File: rtl/sar_pkg.sv
package sar_pkg;
  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,  // address phase over or not begun: ignore bytes
    PH_FIRST  = 2'd1,  // waiting for first address byte
    PH_SECOND = 2'd2   // wide mode: waiting for low address byte
  } phase_t;
endpackage

// File: rtl/sar_rst_sync.sv
module sar_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] shreg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) shreg_q <= '0;
    else        shreg_q <= {shreg_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = shreg_q[STAGES-1];
endmodule

// File: rtl/sar_cmp.sv
module sar_cmp #(
  parameter int          BYTE_W  = 8,
  parameter int          HI_W    = 3,
  parameter int          CARRY_W = 2,
  parameter logic [BYTE_W-2-CARRY_W:0] MARK = '1 << 1
) (
  input  logic [BYTE_W-1:0] byte_i,
  input  logic [BYTE_W-1:0] own_lo_i,
  input  logic [HI_W-1:0]   own_hi_i,
  input  logic              gcall_en_i,
  output logic              gc_hit,
  output logic              a7_hit,
  output logic              mark_hit,
  output logic              lo_hit
);
  localparam int MARK_W = BYTE_W - 1 - CARRY_W;

  logic [BYTE_W-2:0] short_own;
  assign short_own = own_lo_i[BYTE_W-2:0];

  always_comb begin
    gc_hit   = gcall_en_i && (byte_i == '0);
    a7_hit   = (byte_i[BYTE_W-1:1] == short_own) && (short_own != '0);
    mark_hit = (byte_i[BYTE_W-1 -: MARK_W] == MARK) &&
               (byte_i[CARRY_W:1] == own_hi_i[CARRY_W-1:0]);
    lo_hit   = (byte_i == own_lo_i);
  end
endmodule

// File: rtl/sar_ctl.sv
module sar_ctl
  import sar_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic bus_start_i,
  input  logic bus_rstart_i,
  input  logic byte_vld_i,
  input  logic dir_bit,
  input  logic wide_sel_i,
  input  logic gc_hit,
  input  logic a7_hit,
  input  logic mark_hit,
  input  logic lo_hit,
  output logic hit_o,
  output logic gcall_o,
  output logic dir_rd_o
);
  phase_t phase_q, phase_n;
  logic   wrdone_q, wrdone_n;
  logic   gc_q, gc_n;
  logic   dir_q, dir_n;
  logic   hit_q, hit_n;
  logic   any_start, state_en;

  assign any_start = bus_start_i | bus_rstart_i;
  assign state_en  = any_start | byte_vld_i;

  always_comb begin
    phase_n  = phase_q;
    wrdone_n = wrdone_q;
    gc_n     = gc_q;
    dir_n    = dir_q;
    hit_n    = 1'b0;
    if (any_start) begin
      phase_n = PH_FIRST;
      gc_n    = 1'b0;
      if (bus_start_i) wrdone_n = 1'b0;
    end else if (byte_vld_i) begin
      unique case (phase_q)
        PH_FIRST: begin
          phase_n  = PH_IDLE;
          wrdone_n = 1'b0;
          if (gc_hit) begin
            hit_n = 1'b1;
            gc_n  = 1'b1;
            dir_n = 1'b0;
          end else if (!wide_sel_i && a7_hit) begin
            hit_n = 1'b1;
            dir_n = dir_bit;
          end else if (wide_sel_i && mark_hit && !dir_bit) begin
            phase_n = PH_SECOND;
          end else if (wide_sel_i && mark_hit && dir_bit && wrdone_q) begin
            hit_n = 1'b1;
            dir_n = 1'b1;
          end
        end
        PH_SECOND: begin
          phase_n = PH_IDLE;
          if (lo_hit) begin
            hit_n    = 1'b1;
            dir_n    = 1'b0;
            wrdone_n = 1'b1;
          end
        end
        default: phase_n = PH_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q  <= PH_IDLE;
      wrdone_q <= 1'b0;
      gc_q     <= 1'b0;
      dir_q    <= 1'b0;
    end else if (state_en) begin
      phase_q  <= phase_n;
      wrdone_q <= wrdone_n;
      gc_q     <= gc_n;
      dir_q    <= dir_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hit_q <= 1'b0;
    else        hit_q <= hit_n;
  end

  assign hit_o    = hit_q;
  assign gcall_o  = gc_q;
  assign dir_rd_o = dir_q;
endmodule

// File: rtl/slv_addr_recog.sv
module slv_addr_recog #(
  parameter int BYTE_W  = 8,
  parameter int HI_W    = 3,
  parameter int CARRY_W = 2,
  parameter logic [BYTE_W-2-CARRY_W:0] MARK = 5'b11110
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_start_i,
  input  logic              bus_rstart_i,
  input  logic              byte_vld_i,
  input  logic [BYTE_W-1:0] byte_i,
  input  logic [BYTE_W-1:0] own_lo_i,
  input  logic [HI_W-1:0]   own_hi_i,
  input  logic              wide_sel_i,
  input  logic              gcall_en_i,
  output logic              hit_o,
  output logic              gcall_o,
  output logic              dir_rd_o
);
  logic rst_sync_n;
  logic gc_hit, a7_hit, mark_hit, lo_hit;

  sar_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  sar_cmp #(
    .BYTE_W(BYTE_W), .HI_W(HI_W), .CARRY_W(CARRY_W), .MARK(MARK)
  ) u_cmp (
    .byte_i     (byte_i),
    .own_lo_i   (own_lo_i),
    .own_hi_i   (own_hi_i),
    .gcall_en_i (gcall_en_i),
    .gc_hit     (gc_hit),
    .a7_hit     (a7_hit),
    .mark_hit   (mark_hit),
    .lo_hit     (lo_hit)
  );

  sar_ctl u_ctl (
    .clk          (clk),
    .rst_n        (rst_sync_n),
    .bus_start_i  (bus_start_i),
    .bus_rstart_i (bus_rstart_i),
    .byte_vld_i   (byte_vld_i),
    .dir_bit      (byte_i[0]),
    .wide_sel_i   (wide_sel_i),
    .gc_hit       (gc_hit),
    .a7_hit       (a7_hit),
    .mark_hit     (mark_hit),
    .lo_hit       (lo_hit),
    .hit_o        (hit_o),
    .gcall_o      (gcall_o),
    .dir_rd_o     (dir_rd_o)
  );
endmodule

// File: rtl/sar_chk.sv
module sar_chk #(
  parameter int BYTE_W = 8,
  parameter int HI_W   = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_start_i,
  input logic              bus_rstart_i,
  input logic              byte_vld_i,
  input logic [BYTE_W-1:0] byte_i,
  input logic [BYTE_W-1:0] own_lo_i,
  input logic [HI_W-1:0]   own_hi_i,
  input logic              wide_sel_i,
  input logic              gcall_en_i,
  input logic              hit_o,
  input logic              gcall_o,
  input logic              dir_rd_o
);
  AST_HIT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    hit_o |=> !hit_o); // R10

  AST_HIT_NEEDS_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    hit_o |-> $past(byte_vld_i)); // R10

  AST_START_DISCARDS: assert property (@(posedge clk) disable iff (!rst_n)
    $past(bus_start_i || bus_rstart_i) |-> !hit_o && !gcall_o); // R8

  AST_GCALL_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gcall_o) |-> $past(gcall_en_i) && ($past(byte_i) == '0) && hit_o); // R3

  AST_NARROW_DIR: assert property (@(posedge clk) disable iff (!rst_n)
    hit_o && $past(!wide_sel_i) |-> dir_rd_o == $past(byte_i[0])); // R2

  AST_DIR_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !hit_o |-> $stable(dir_rd_o)); // R11
endmodule

bind slv_addr_recog sar_chk #(.BYTE_W(BYTE_W), .HI_W(HI_W)) u_chk (.*);

// File: tb/slv_addr_recog_test.sv
module slv_addr_recog_test;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       bus_start_i, bus_rstart_i, byte_vld_i;
  logic [7:0] byte_i, own_lo_i;
  logic [2:0] own_hi_i;
  logic       wide_sel_i, gcall_en_i;
  logic       hit_o, gcall_o, dir_rd_o;

  int errors = 0;
  int checks = 0;

  // bench model of the requirements
  int   m_phase;   // 0 ignore, 1 first byte, 2 low byte
  logic m_wr;      // completed wide write, read may follow
  logic m_gc, m_dir;

  always #10 clk = ~clk;  // 50 MHz

  slv_addr_recog uut (.*);

  initial begin
    #2_000_000;
    errors++; checks++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  task automatic chk(input string tag, input logic [2:0] act, input logic [2:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: {hit,gcall,dir} actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic outs(input string tag, input logic exp_hit);
    chk(tag, {hit_o, gcall_o, dir_rd_o}, {exp_hit, m_gc, m_dir});
  endtask

  // expected hit for a byte, updating the model
  function automatic logic model_byte(input logic [7:0] b);
    logic h = 1'b0;
    logic prev_wr = m_wr;
    if (m_phase == 1) begin
      m_phase = 0;
      m_wr = 1'b0;
      if (gcall_en_i && b == 8'h00) begin
        h = 1'b1; m_gc = 1'b1; m_dir = 1'b0;
      end else if (!wide_sel_i) begin
        if (b[7:1] == own_lo_i[6:0] && own_lo_i[6:0] != 7'd0) begin
          h = 1'b1; m_dir = b[0];
        end
      end else if (b[7:3] == 5'b11110 && b[2:1] == own_hi_i[1:0]) begin
        if (!b[0]) m_phase = 2;
        else if (prev_wr) begin h = 1'b1; m_dir = 1'b1; end
      end
    end else if (m_phase == 2) begin
      m_phase = 0;
      if (b == own_lo_i) begin h = 1'b1; m_dir = 1'b0; m_wr = 1'b1; end
    end
    return h;
  endfunction

  task automatic start(input logic rep);
    @(negedge clk);
    bus_start_i = !rep; bus_rstart_i = rep;
    @(negedge clk);
    bus_start_i = 1'b0; bus_rstart_i = 1'b0;
    m_phase = 1; m_gc = 1'b0;
    if (!rep) m_wr = 1'b0;
  endtask

  task automatic send(input logic [7:0] b, input string tag);
    logic eh;
    @(negedge clk);
    byte_vld_i = 1'b1; byte_i = b;
    eh = model_byte(b);
    @(negedge clk);
    byte_vld_i = 1'b0;
    outs(tag, eh);
  endtask

  task automatic cfg(input logic w, input logic g, input logic [7:0] lo, input logic [2:0] hi);
    wide_sel_i = w; gcall_en_i = g; own_lo_i = lo; own_hi_i = hi;
  endtask

  function automatic logic [7:0] mark(input logic [2:0] hi, input logic rd);
    return {5'b11110, hi[1:0], rd};
  endfunction

  initial begin
    bus_start_i = 0; bus_rstart_i = 0; byte_vld_i = 0; byte_i = 0;
    cfg(1'b0, 1'b1, 8'h2A, 3'd0);
    m_phase = 0; m_wr = 0; m_gc = 0; m_dir = 0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    outs("R1 reset state", 1'b0);
    send(8'h54, "R1 byte before START ignored");
    send(8'h00, "R1 gc byte before START ignored");

    // narrow mode
    start(1'b0); send(8'h55, "R2 narrow read hit");
    send(8'h54, "R9 byte after hit ignored");
    chk("R10 hit dropped", {2'b00, hit_o}, 3'b000);
    start(1'b0); send(8'h54, "R2 narrow write hit");
    start(1'b0); send(8'h56, "R2 narrow mismatch");
    send(8'h54, "R9 byte after miss ignored");
    start(1'b0); send(8'h00, "R3 general call enabled");
    chk("R3 gcall sticky", {1'b0, gcall_o, 1'b0}, 3'b010);
    start(1'b1); outs("R3 gcall cleared by restart", 1'b0);
    cfg(1'b0, 1'b0, 8'h2A, 3'd0);
    start(1'b0); send(8'h00, "R3 general call disabled");
    cfg(1'b0, 1'b0, 8'h80, 3'd7);
    start(1'b0); send(8'h00, "R4 own zero never hits");
    start(1'b0); send(8'h01, "R4 own zero read never hits");
    cfg(1'b0, 1'b0, 8'hAA, 3'd5);
    start(1'b0); send(8'h55, "R4 lo bit7 and hi ignored in narrow");
    send(8'h55, "R11 dir holds");

    // start and byte in the same cycle
    start(1'b0);
    @(negedge clk);
    bus_start_i = 1; byte_vld_i = 1; byte_i = 8'h54;
    @(negedge clk);
    bus_start_i = 0; byte_vld_i = 0;
    m_phase = 1; m_gc = 0; m_wr = 0;
    outs("R8 START wins over byte", 1'b0);
    send(8'h54, "R8 waits for new first byte");

    // wide mode
    cfg(1'b1, 1'b1, 8'h3C, 3'b010);
    start(1'b0); send(mark(3'b010, 1'b0), "R5 marker no pulse");
    send(8'h3C, "R5 low byte hit");
    start(1'b1); send(mark(3'b010, 1'b1), "R7 read after restart hit");
    start(1'b1); send(mark(3'b010, 1'b1), "R7 second read refused");
    start(1'b0); send(mark(3'b010, 1'b0), "R5 marker");
    send(8'h3D, "R5 wrong low byte");
    start(1'b0); send(mark(3'b010, 1'b0), "R5 marker");
    send(8'h3C, "R5 hit again");
    start(1'b0); send(mark(3'b010, 1'b1), "R7 read after plain START refused");
    cfg(1'b1, 1'b1, 8'h3C, 3'b110);
    start(1'b0); send(mark(3'b010, 1'b0), "R6 top bit ignored marker");
    send(8'h3C, "R6 top bit ignored hit");
    start(1'b0); send(mark(3'b011, 1'b0), "R5 wrong upper bits");
    send(8'h3C, "R9 ignored after bad marker");
    start(1'b0); send(8'h00, "R3 general call in wide mode");

    // constrained random mix
    void'($urandom(32'h5A17));
    for (int t = 0; t < 400; t++) begin
      logic [7:0] lo = $urandom;
      logic [2:0] hi = $urandom;
      if (t % 8 == 0)
        cfg($urandom_range(0, 1), $urandom_range(0, 1), lo, hi);
      start($urandom_range(0, 2) == 0 ? 1'b0 : (m_wr ? 1'b1 : 1'(($urandom_range(0, 1)))));
      for (int k = 0; k < 3; k++) begin
        logic [7:0] b;
        case ($urandom_range(0, 5))
          0: b = 8'h00;
          1: b = {own_lo_i[6:0], 1'($urandom_range(0, 1))};
          2: b = mark(own_hi_i, 1'b0);
          3: b = mark(own_hi_i, 1'b1);
          4: b = own_lo_i;
          default: b = $urandom;
        endcase
        send(b, "R2 R3 R5 R7 R9 random");
      end
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule